// File: doc/BRIEF.md
# Fused multiply-add special-operand result selector

This block is the decision stage at the front of a double-precision fused multiply-add unit. The unit computes z + (x × y). A mode input negates the product, which gives the multiply-subtract form. Each of the three operands arrives with its class code from an upstream classifier and its raw word. The block decides whether the final result is already known from the operand classes or whether the arithmetic datapath has to compute it.

When the result is known, the block returns it as a bypass word, together with an invalid-operation flag. Otherwise it raises a proceed signal and passes on the effective product sign. The operation is decided first by the class pair of the two multiplicands and then refined by the class of the addend. Signalling NaNs take priority over everything else. A denormal addend is flushed to a signed zero before any decision is taken.

The decision logic is combinational. Its result lands in a registered output stage that works as a small state machine with three states:
- ST_IDLE: no result is held.
- ST_BYPASS: a special-case result is held.
- ST_PROCEED: the datapath has to compute the result.

On every clock edge the state moves as follows:
- IDLE transition: to ST_IDLE when in_valid is low.
- SHORTCUT transition: to ST_BYPASS when a valid operation has a class-determined result.
- COMPUTE transition: to ST_PROCEED for every other valid operation.

Reset puts the state in ST_IDLE.

Top module: `fma_special_sel`

## Requirements
- R1: Class codes are 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN, 5 signalling NaN. Results appear one clock after in_valid is sampled high, with out_valid high. After a cycle with in_valid low, or during reset, out_valid, byp_valid, proceed and invalid are all low.
- R2: A signalling-NaN addend gives a bypass of z with bit 51 set, and invalid high. This takes precedence over every other case.
- R3: Otherwise, a signalling-NaN x gives x with bit 51 set, whatever the class of y. If only y is a signalling NaN, the result is y with bit 51 set. Both cases set invalid.
- R4: If there is no signalling NaN and a multiplicand is a quiet NaN, that multiplicand is returned unchanged without invalid, with x preferred over y.
- R5: Infinity times zero, in either order, gives invalid and the default NaN 0x7FF8000000000000. When z is a quiet NaN, the result is instead z unchanged, without invalid.
- R6: Infinity times a nonzero finite value or an infinity gives an infinity with sign x_sign XOR y_sign XOR neg_prod. When z is a quiet NaN, the result is z instead.
- R7: When either multiplicand is zero (and the case is not covered by R2 to R5), the result is z. An infinite z becomes an infinity with z's sign, and a denormal z becomes a zero with z's sign.
- R8: For two nonzero finite multiplicands, a quiet-NaN z is returned, and an infinite z becomes an infinity with z's sign. Otherwise proceed is raised, byp_word is zero and invalid is low.
- R9: When out_valid is high, prod_sgn equals x_sign XOR y_sign XOR neg_prod of the sampled operation.
- R10: When out_valid is high, exactly one of byp_valid and proceed is high, and invalid never accompanies proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| neg_prod | input | 1 | Negate the product (multiply-subtract) |
| x_cls | input | 3 | Class code of x |
| y_cls | input | 3 | Class code of y |
| z_cls | input | 3 | Class code of the addend z |
| x_word | input | 64 | Raw x, sign in the top bit |
| y_word | input | 64 | Raw y, sign in the top bit |
| z_word | input | 64 | Raw z, sign in the top bit |
| out_valid | output | 1 | Registered decision available |
| byp_valid | output | 1 | Result is given by byp_word |
| byp_word | output | 64 | Special-case result word |
| invalid | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Result must come from the datapath |
| prod_sgn | output | 1 | Effective product sign |

## Verification
The bench builds the block with its default 11-bit exponent and 52-bit fraction. This puts the real double-precision encodings within reach, including the default NaN constant and the quiet bit at position 51. The bench sweeps every class triple of x, y and z against every combination of the three operand signs and both mode values, which visits each precedence path. Operand payloads differ between x, y and z, so a wrong choice between returning one NaN or another shows up in the result word.

// File: rtl/fma_sel_pkg.sv
package fma_sel_pkg;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_NORM = 3'd1,
        CL_DNRM = 3'd2,
        CL_INF  = 3'd3,
        CL_QNAN = 3'd4,
        CL_SNAN = 3'd5
    } fcls_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BYPASS  = 2'd1,
        ST_PROCEED = 2'd2
    } sel_state_t;

endpackage

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
    import fma_sel_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  fcls_t             x_cls,
    input  fcls_t             y_cls,
    input  fcls_t             z_cls,
    input  logic [WORD_W-1:0] x_word,
    input  logic [WORD_W-1:0] y_word,
    input  logic [WORD_W-1:0] z_word,
    output logic              hit,
    output logic [WORD_W-1:0] word,
    output logic              inv
);
    localparam logic [WORD_W-1:0] QUIET = WORD_W'(1) << (FRAC_W - 1);

    // Priority: signalling z, signalling x, signalling y, quiet x, quiet y.
    always_comb begin
        hit  = 1'b1;
        inv  = 1'b1;
        word = '0;
        if (z_cls == CL_SNAN) begin
            word = z_word | QUIET;
        end else if (x_cls == CL_SNAN) begin
            word = x_word | QUIET;
        end else if (y_cls == CL_SNAN) begin
            word = y_word | QUIET;
        end else if (x_cls == CL_QNAN) begin
            word = x_word;
            inv  = 1'b0;
        end else if (y_cls == CL_QNAN) begin
            word = y_word;
            inv  = 1'b0;
        end else begin
            hit = 1'b0;
            inv = 1'b0;
        end
    end

endmodule

// File: rtl/fma_prod_case.sv
module fma_prod_case
    import fma_sel_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  fcls_t             x_cls,
    input  fcls_t             y_cls,
    input  fcls_t             z_cls,   // already flushed: never CL_DNRM
    input  logic [WORD_W-1:0] z_word,  // already flushed
    input  logic              psgn,
    output logic              byp,
    output logic [WORD_W-1:0] word,
    output logic              inv
);
    localparam logic [WORD_W-1:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic x_inf, y_inf, x_zero, y_zero, z_qnan, z_inf, zs;

    assign x_inf  = (x_cls == CL_INF);
    assign y_inf  = (y_cls == CL_INF);
    assign x_zero = (x_cls == CL_ZERO);
    assign y_zero = (y_cls == CL_ZERO);
    assign z_qnan = (z_cls == CL_QNAN);
    assign z_inf  = (z_cls == CL_INF);
    assign zs     = z_word[WORD_W-1];

    function automatic logic [WORD_W-1:0] inf_word(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    always_comb begin
        byp  = 1'b1;
        inv  = 1'b0;
        word = '0;
        if ((x_inf && y_zero) || (x_zero && y_inf)) begin
            if (z_qnan) word = z_word;
            else begin
                word = DFLT_NAN;
                inv  = 1'b1;
            end
        end else if (x_inf || y_inf) begin
            word = z_qnan ? z_word : inf_word(psgn);
        end else if (x_zero || y_zero) begin
            word = z_inf ? inf_word(zs) : z_word;
        end else if (z_qnan) begin
            word = z_word;
        end else if (z_inf) begin
            word = inf_word(zs);
        end else begin
            byp = 1'b0;
        end
    end

endmodule

// File: rtl/fma_special_sel.sv
module fma_special_sel
    import fma_sel_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              neg_prod,
    input  logic [2:0]        x_cls,
    input  logic [2:0]        y_cls,
    input  logic [2:0]        z_cls,
    input  logic [WORD_W-1:0] x_word,
    input  logic [WORD_W-1:0] y_word,
    input  logic [WORD_W-1:0] z_word,
    output logic              out_valid,
    output logic              byp_valid,
    output logic [WORD_W-1:0] byp_word,
    output logic              invalid,
    output logic              proceed,
    output logic              prod_sgn
);
    fcls_t             xc, yc, zc_raw, zc;
    logic [WORD_W-1:0] z_eff;
    logic              psgn_d;
    logic              nan_hit, nan_inv, pc_byp, pc_inv;
    logic [WORD_W-1:0] nan_word, pc_word;

    sel_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic              inv_q, inv_d, psgn_q;

    assign xc     = fcls_t'(x_cls);
    assign yc     = fcls_t'(y_cls);
    assign zc_raw = fcls_t'(z_cls);
    assign zc     = (zc_raw == CL_DNRM) ? CL_ZERO : zc_raw;
    assign z_eff  = (zc_raw == CL_DNRM) ? {z_word[WORD_W-1], {(WORD_W-1){1'b0}}} : z_word;
    assign psgn_d = x_word[WORD_W-1] ^ y_word[WORD_W-1] ^ neg_prod;

    fma_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
        .x_cls (xc),
        .y_cls (yc),
        .z_cls (zc),
        .x_word(x_word),
        .y_word(y_word),
        .z_word(z_eff),
        .hit   (nan_hit),
        .word  (nan_word),
        .inv   (nan_inv)
    );

    fma_prod_case #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_prod (
        .x_cls (xc),
        .y_cls (yc),
        .z_cls (zc),
        .z_word(z_eff),
        .psgn  (psgn_d),
        .byp   (pc_byp),
        .word  (pc_word),
        .inv   (pc_inv)
    );

    // Next-state and held-result selection
    always_comb begin
        state_d = ST_IDLE;
        word_d  = '0;
        inv_d   = 1'b0;
        if (in_valid) begin
            if (nan_hit) begin
                state_d = ST_BYPASS;
                word_d  = nan_word;
                inv_d   = nan_inv;
            end else if (pc_byp) begin
                state_d = ST_BYPASS;
                word_d  = pc_word;
                inv_d   = pc_inv;
            end else begin
                state_d = ST_PROCEED;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            inv_q   <= 1'b0;
            psgn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            inv_q   <= inv_d;
            psgn_q  <= psgn_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        out_valid = 1'b0;
        byp_valid = 1'b0;
        proceed   = 1'b0;
        invalid   = 1'b0;
        byp_word  = '0;
        prod_sgn  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BYPASS: begin
                out_valid = 1'b1;
                byp_valid = 1'b1;
                byp_word  = word_q;
                invalid   = inv_q;
                prod_sgn  = psgn_q;
            end
            ST_PROCEED: begin
                out_valid = 1'b1;
                proceed   = 1'b1;
                prod_sgn  = psgn_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fma_special_sel_chk.sv
module fma_special_sel_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        z_cls,
    input logic [WORD_W-1:0] z_word,
    input logic              out_valid,
    input logic              byp_valid,
    input logic [WORD_W-1:0] byp_word,
    input logic              invalid,
    input logic              proceed
);
    localparam logic [WORD_W-1:0] QUIET = WORD_W'(1) << (FRAC_W - 1);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid || byp_valid || proceed || invalid)); // R1
    AST_ZSNAN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_cls == 3'd5) |=>
        (byp_valid && invalid && byp_word == ($past(z_word) | QUIET))); // R2
    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({byp_valid, proceed})); // R10
    AST_PROCEED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        proceed |-> !invalid); // R10

endmodule

bind fma_special_sel fma_special_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .z_cls    (z_cls),
    .z_word   (z_word),
    .out_valid(out_valid),
    .byp_valid(byp_valid),
    .byp_word (byp_word),
    .invalid  (invalid),
    .proceed  (proceed)
);

// File: tb/fma_special_sel_bench.sv
module fma_special_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        neg_prod = 1'b0;
    logic [2:0]  x_cls = '0, y_cls = '0, z_cls = '0;
    logic [63:0] x_word = '0, y_word = '0, z_word = '0;
    logic        out_valid, byp_valid, invalid, proceed, prod_sgn;
    logic [63:0] byp_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_sel u_fma_special_sel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .neg_prod(neg_prod),
        .x_cls(x_cls), .y_cls(y_cls), .z_cls(z_cls),
        .x_word(x_word), .y_word(y_word), .z_word(z_word),
        .out_valid(out_valid), .byp_valid(byp_valid), .byp_word(byp_word),
        .invalid(invalid), .proceed(proceed), .prod_sgn(prod_sgn)
    );

    function automatic logic [63:0] mk(input int c, input logic s, input int idx);
        logic [50:0] pl = 51'h1_0000 + 51'(idx) * 51'h111;
        case (c)
            0: return {s, 63'h0};
            1: return {s, 11'h400, 52'h0_1234_5678_9AB0 + 52'(idx)};
            2: return {s, 11'h000, 52'h0_0000_0000_0AB0 + 52'(idx)};
            3: return {s, 11'h7FF, 52'h0};
            4: return {s, 11'h7FF, 1'b1, pl};
            default: return {s, 11'h7FF, 1'b0, pl};
        endcase
    endfunction

    function automatic logic [63:0] infw(input logic s);
        return {s, 11'h7FF, 52'h0};
    endfunction

    // Reference from the requirements; kind 1 = bypass, 2 = proceed
    task automatic model(input int xc, input int yc, input int zc,
                         input logic [63:0] xw, input logic [63:0] yw, input logic [63:0] zw,
                         input logic np, output int kind, output logic [63:0] w,
                         output logic inv, output string tag);
        logic ps = xw[63] ^ yw[63] ^ np;
        logic [63:0] zf = (zc == 2) ? {zw[63], 63'h0} : zw;
        bit xz = (xc == 0), yz = (yc == 0), xi = (xc == 3), yi = (yc == 3);
        kind = 1; inv = 1'b0; w = '0;
        if (zc == 5) begin w = zw | (64'd1 << 51); inv = 1; tag = "R2"; end
        else if (xc == 5) begin w = xw | (64'd1 << 51); inv = 1; tag = "R3"; end
        else if (yc == 5) begin w = yw | (64'd1 << 51); inv = 1; tag = "R3"; end
        else if (xc == 4) begin w = xw; tag = "R4"; end
        else if (yc == 4) begin w = yw; tag = "R4"; end
        else if ((xi && yz) || (xz && yi)) begin
            tag = "R5";
            if (zc == 4) w = zw; else begin w = 64'h7FF8_0000_0000_0000; inv = 1; end
        end else if (xi || yi) begin
            tag = "R6"; w = (zc == 4) ? zw : infw(ps);
        end else if (xz || yz) begin
            tag = "R7"; w = (zc == 3) ? infw(zw[63]) : zf;
        end else begin
            tag = "R8";
            if (zc == 4) w = zw;
            else if (zc == 3) w = infw(zw[63]);
            else kind = 2;
        end
    endtask

    task automatic chk_idle(input string tag);
        checks++;
        if (out_valid || byp_valid || proceed || invalid) begin
            failures++;
            $display("FAIL %s idle: got v=%0b b=%0b p=%0b i=%0b expected all 0",
                     tag, out_valid, byp_valid, proceed, invalid);
        end
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        for (int xc = 0; xc < 6; xc++)
        for (int yc = 0; yc < 6; yc++)
        for (int zc = 0; zc < 6; zc++)
        for (int sg = 0; sg < 8; sg++)
        for (int np = 0; np < 2; np++) begin
            int kind; logic [63:0] ew; logic ei; string tag;
            logic eps;
            in_valid = 1'b1;
            neg_prod = np[0];
            x_cls = 3'(xc); y_cls = 3'(yc); z_cls = 3'(zc);
            x_word = mk(xc, sg[0], 1);
            y_word = mk(yc, sg[1], 2);
            z_word = mk(zc, sg[2], 3);
            model(xc, yc, zc, x_word, y_word, z_word, np[0], kind, ew, ei, tag);
            eps = sg[0] ^ sg[1] ^ np[0];
            @(negedge clk);
            checks++;
            if (kind == 1) begin
                if (!(out_valid && byp_valid && !proceed && byp_word == ew && invalid == ei && prod_sgn == eps)) begin
                    failures++;
                    $display("FAIL %s/R9/R10 x=%0d y=%0d z=%0d s=%0d n=%0d: got v=%0b b=%0b p=%0b w=%h i=%0b ps=%0b expected v=1 b=1 p=0 w=%h i=%0b ps=%0b",
                             tag, xc, yc, zc, sg, np, out_valid, byp_valid, proceed, byp_word, invalid, prod_sgn, ew, ei, eps);
                end
            end else begin
                if (!(out_valid && !byp_valid && proceed && byp_word == 64'h0 && !invalid && prod_sgn == eps)) begin
                    failures++;
                    $display("FAIL R8/R9/R10 x=%0d y=%0d z=%0d s=%0d n=%0d: got v=%0b b=%0b p=%0b w=%h i=%0b ps=%0b expected v=1 b=0 p=1 w=0 i=0 ps=%0b",
                             xc, yc, zc, sg, np, out_valid, byp_valid, proceed, byp_word, invalid, prod_sgn, eps);
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk_idle("R1 gap");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule